// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block keeps a small register file of segment registers. Each register has a visible selector and a hidden cached descriptor made of a base, a limit, a privilege level and type flags. Translation never reads a descriptor table. It always uses the cached copy. That copy changes only when a load request names the register. A selector-only write and a change of the mode input both leave every cached copy as it was.

A load request brings a selector and a 64-bit descriptor that an outside agent has already fetched. The block checks the pair and fills the cache, or reports a fault and leaves the cache untouched. An access request names a register, a 32-bit offset and an access kind (read, write or instruction fetch). The block returns either a linear address or a fault code. The mode input selects one of two address forms. In legacy mode the address is segment-times-sixteen plus offset. In protected mode it is the checked base plus offset. The current privilege level (CPL) is always the low two bits of the visible selector of register 0, which is the code-segment register.

Top module: `segu_top`

## Requirements
- R1: In legacy mode (`prot_mode`=0) an access returns fault 0 and a linear address equal to (cached base + offset[15:0]) modulo 2^20, zero-extended to 32 bits. The access kind and offset bits above bit 15 have no effect.
- R2: In legacy mode a load never faults. It caches base = selector×16, limit 0xFFFF, present, privilege 0, executable and read/write. It also stores the selector.
- R3: In protected mode, an access whose offset exceeds the cached limit returns fault 1 and address 0. Otherwise the address is cached base + offset (mod 2^32).
- R4: In protected mode, a type violation returns fault 3 and address 0. The cases are: a write (kind 1) to an executable segment or to one without the read/write flag; a fetch (kind 2) from a non-executable segment; a read (kind 0) from an executable segment without the read/write flag. The limit check takes priority over the type check.
- R5: A protected load into registers 1..N-1 faults with code 2 when max(CPL, selector[1:0]) is greater than the descriptor privilege level.
- R6: A protected load into register 0 needs the executable flag (otherwise fault 3) and a descriptor privilege level equal to CPL (otherwise fault 2). On success the stored selector's low two bits are set to that level, so CPL does not change.
- R7: A protected load with the present bit clear faults with code 4. Type and privilege faults take priority over it. No faulted load changes any cached descriptor or selector.
- R8: A selector-only write changes only the visible selector (for register 0, therefore CPL). Later translations use the old cached base, limit and flags.
- R9: Changing `prot_mode` reloads no cache. A register loaded in one mode keeps its cached base when accessed in the other mode.
- R10: Each load or access request gives exactly one response, with `ld_ack` or `ac_ack` high for the single cycle after the request.
- R11: After reset every cache holds base 0, limit 0xFFFF, present, privilege 0, executable and read/write. All selectors are 0, so CPL is 0, and both acknowledges are low.
- R12: Descriptor layout: base in bits [31:0], limit in [51:32], present in bit 56, privilege level in [58:57], executable in bit 59, read/write in bit 60. Other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_mode | input | 1 | 1 = descriptor-based, 0 = legacy shift-and-add |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 2 | Register index for load |
| ld_sel | input | 16 | Selector to load |
| ld_desc | input | 64 | Pre-fetched descriptor |
| sw_valid | input | 1 | Selector-only write request |
| sw_seg | input | 2 | Register index for selector write |
| sw_sel | input | 16 | Selector value for selector write |
| ac_valid | input | 1 | Access request |
| ac_seg | input | 2 | Register index for access |
| ac_ofs | input | 32 | Access offset |
| ac_kind | input | 2 | 0 read, 1 write, 2 fetch |
| ld_ack | output | 1 | Load response valid |
| ld_fault | output | 3 | Load fault code (0 none, 2 privilege, 3 type, 4 not present) |
| ac_ack | output | 1 | Access response valid |
| ac_fault | output | 3 | Access fault code (0 none, 1 limit, 3 type) |
| ac_lin | output | 32 | Linear address, 0 on fault |
| cur_cpl | output | 2 | Current privilege level |

## Verification
Both load and access results are registered, so each one appears exactly one rising edge after its request. A cache update made by a load is visible to an access issued in the next cycle. The bench drives every request on a falling edge, releases it on the following falling edge and samples the response at that same point, which is half a period after the edge that produced it. Effects that cannot be seen directly are checked with a follow-up access one cycle later: a faulted load leaving the cache alone, a selector-only write, and a mode switch. The same applies to CPL, which is observed on `cur_cpl` after the edge that changes it.

// File: rtl/segu_pkg.sv
// Shared widths, descriptor bit positions, fault and access codes, and the
// cached-descriptor record for the segment translation unit.
package segu_pkg;
    localparam int SEL_W  = 16;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 20;
    localparam int DESC_W = 64;
    localparam int LEG_W  = 20;

    // Descriptor field positions
    localparam int D_LIM_LO = 32;
    localparam int D_P      = 56;
    localparam int D_DPL_LO = 57;
    localparam int D_X      = 59;
    localparam int D_RW     = 60;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_LIMIT  = 3'd1,
        FLT_PRIV   = 3'd2,
        FLT_TYPE   = 3'd3,
        FLT_ABSENT = 3'd4
    } flt_e;

    typedef enum logic [1:0] {
        ACC_RD    = 2'd0,
        ACC_WR    = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              present;
        logic [1:0]        dpl;
        logic              exec;
        logic              rw;
    } seg_cache_t;

    localparam seg_cache_t RESET_CACHE = '{
        base: '0, limit: 20'h0FFFF, present: 1'b1, dpl: 2'd0, exec: 1'b1, rw: 1'b1
    };
endpackage

// File: rtl/segu_load_check.sv
// Validates a selector/descriptor pair offered for a segment load and forms the
// cache entry and stored selector. Purely combinational.
// Assumes: the descriptor is already fetched; code_reg marks register 0.
module segu_load_check
    import segu_pkg::*;
(
    input  logic              prot_mode,
    input  logic              code_reg,
    input  logic [1:0]        cpl,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [DESC_W-1:0] desc,
    output flt_e              fault,
    output seg_cache_t        entry,
    output logic [SEL_W-1:0]  sel_out
);
    logic [1:0] rpl;
    logic [1:0] epl;
    logic [1:0] d_dpl;
    logic       d_p;
    logic       d_x;
    logic       d_rw;

    // Extract the descriptor fields and the effective privilege level
    always_comb begin
        rpl   = sel_in[1:0];
        epl   = (cpl > rpl) ? cpl : rpl;
        d_dpl = desc[D_DPL_LO +: 2];
        d_p   = desc[D_P];
        d_x   = desc[D_X];
        d_rw  = desc[D_RW];
    end

    // Build the entry and choose a fault: type first, then privilege, then presence
    always_comb begin
        fault   = FLT_NONE;
        sel_out = sel_in;
        if (!prot_mode) begin
            entry = '{base: {{(ADDR_W-SEL_W-4){1'b0}}, sel_in, 4'b0000},
                      limit: 20'h0FFFF, present: 1'b1, dpl: 2'd0,
                      exec: 1'b1, rw: 1'b1};
        end else begin
            entry = '{base: desc[ADDR_W-1:0], limit: desc[D_LIM_LO +: LIM_W],
                      present: d_p, dpl: d_dpl, exec: d_x, rw: d_rw};
            if (code_reg) begin
                sel_out = {sel_in[SEL_W-1:2], d_dpl};
                if (!d_x)
                    fault = FLT_TYPE;
                else if (d_dpl != cpl)
                    fault = FLT_PRIV;
            end else if (epl > d_dpl) begin
                fault = FLT_PRIV;
            end
            if (fault == FLT_NONE && !d_p)
                fault = FLT_ABSENT;
        end
    end
endmodule

// File: rtl/segu_xlate.sv
// Turns one cached descriptor plus an offset and access kind into a linear
// address or a fault code. Purely combinational.
// Assumes: the entry given is the current hidden cache of the named register.
module segu_xlate
    import segu_pkg::*;
(
    input  logic              prot_mode,
    input  seg_cache_t        entry,
    input  logic [ADDR_W-1:0] ofs,
    input  logic [1:0]        kind,
    output flt_e              fault,
    output logic [ADDR_W-1:0] lin
);
    logic [LEG_W-1:0] leg_sum;
    logic             type_bad;

    // Legacy sum wraps inside the 20-bit space
    always_comb leg_sum = entry.base[LEG_W-1:0] + LEG_W'(ofs[15:0]);

    // Decide whether the access kind is allowed by the cached type flags
    always_comb begin
        case (kind)
            ACC_WR:    type_bad = entry.exec || !entry.rw;
            ACC_FETCH: type_bad = !entry.exec;
            default:   type_bad = entry.exec && !entry.rw;
        endcase
    end

    // Select the address form and apply limit-then-type checks
    always_comb begin
        fault = FLT_NONE;
        lin   = '0;
        if (!prot_mode) begin
            lin = {{(ADDR_W-LEG_W){1'b0}}, leg_sum};
        end else if (ofs > ADDR_W'(entry.limit)) begin
            fault = FLT_LIMIT;
        end else if (type_bad) begin
            fault = FLT_TYPE;
        end else begin
            lin = entry.base + ofs;
        end
    end
endmodule

// File: rtl/segu_top.sv
// Segment register file with hidden descriptor caches, a load port that
// validates pre-fetched descriptors, and an access port that returns a linear
// address or fault. Responses are registered one cycle after each request.
// Assumes: register 0 is the code-segment register holding CPL.
module segu_top
    import segu_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [15:0]       ld_sel,
    input  logic [63:0]       ld_desc,
    input  logic              sw_valid,
    input  logic [SEG_W-1:0]  sw_seg,
    input  logic [15:0]       sw_sel,
    input  logic              ac_valid,
    input  logic [SEG_W-1:0]  ac_seg,
    input  logic [31:0]       ac_ofs,
    input  logic [1:0]        ac_kind,
    output logic              ld_ack,
    output logic [2:0]        ld_fault,
    output logic              ac_ack,
    output logic [2:0]        ac_fault,
    output logic [31:0]       ac_lin,
    output logic [1:0]        cur_cpl
);
    seg_cache_t         cache_q [NUM_SEG];
    logic [SEL_W-1:0]   sel_q   [NUM_SEG];
    logic [SEG_W-1:0]   ld_seg_q;

    flt_e               ld_flt_c;
    seg_cache_t         ld_entry_c;
    logic [SEL_W-1:0]   ld_sel_c;
    flt_e               ac_flt_c;
    logic [ADDR_W-1:0]  ac_lin_c;

    // CPL is the low two bits of the code-segment selector
    always_comb cur_cpl = sel_q[0][1:0];

    segu_load_check u_load (
        .prot_mode (prot_mode),
        .code_reg  (ld_seg == '0),
        .cpl       (cur_cpl),
        .sel_in    (ld_sel),
        .desc      (ld_desc),
        .fault     (ld_flt_c),
        .entry     (ld_entry_c),
        .sel_out   (ld_sel_c)
    );

    segu_xlate u_xlate (
        .prot_mode (prot_mode),
        .entry     (cache_q[ac_seg]),
        .ofs       (ac_ofs),
        .kind      (ac_kind),
        .fault     (ac_flt_c),
        .lin       (ac_lin_c)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        // Update one register: a clean load fills cache and selector, a selector write only the selector
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cache_q[g] <= RESET_CACHE;
                sel_q[g]   <= '0;
            end else if (ld_valid && ld_seg == SEG_W'(g) && ld_flt_c == FLT_NONE) begin
                cache_q[g] <= ld_entry_c;
                sel_q[g]   <= ld_sel_c;
            end else if (sw_valid && sw_seg == SEG_W'(g)) begin
                sel_q[g]   <= sw_sel;
            end
        end

        a_r9_cache_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
            !(ld_valid && ld_seg == SEG_W'(g)) |=> $stable(cache_q[g]));

        a_r7_fault_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_ack && ld_fault != 3'd0 && ld_seg_q == SEG_W'(g))
            |-> (cache_q[g] == $past(cache_q[g]) && sel_q[g] == $past(sel_q[g])));
    end

    // Register the load response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_ack   <= 1'b0;
            ld_fault <= 3'd0;
            ld_seg_q <= '0;
        end else begin
            ld_ack   <= ld_valid;
            ld_fault <= ld_valid ? ld_flt_c : 3'd0;
            ld_seg_q <= ld_seg;
        end
    end

    // Register the access response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_ack   <= 1'b0;
            ac_fault <= 3'd0;
            ac_lin   <= '0;
        end else begin
            ac_ack   <= ac_valid;
            ac_fault <= ac_valid ? ac_flt_c : 3'd0;
            ac_lin   <= ac_valid ? ac_lin_c : '0;
        end
    end

    a_r3_fault_hides_address: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_ack && ac_fault != 3'd0) |-> ac_lin == '0);

    a_r1_legacy_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_ack && !$past(prot_mode)) |-> (ac_fault == 3'd0 && ac_lin[31:20] == '0));

    a_r6_cpl_moves_only_via_reg0: assert property (@(posedge clk) disable iff (!rst_n)
        !((ld_valid && ld_seg == '0) || (sw_valid && sw_seg == '0)) |=> $stable(cur_cpl));

    a_r6_code_cache_executable: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ack && ld_fault == 3'd0 && ld_seg_q == '0) |-> cache_q[0].exec);
endmodule

// File: tb/segu_top_bench.sv
module segu_top_bench;
    localparam logic [1:0] OP_L = 2'd0, OP_A = 2'd1, OP_S = 2'd2;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic        mode;
        logic [1:0]  seg;
        logic [15:0] sel;
        logic [63:0] desc;
        logic [31:0] ofs;
        logic [1:0]  kind;
        logic [2:0]  ef;
        logic [31:0] el;
    } vec_t;

    // R12 layout: base[31:0] limit[51:32] present[56] dpl[58:57] exec[59] rw[60]
    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                       input logic p, input logic [1:0] d,
                                       input logic x, input logic rw);
        mk = {3'b000, rw, x, d, p, 4'h0, l, b};
    endfunction

    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  OP_L, 1'b0, 2'd1, 16'h1234, 64'h0, 32'h0, 2'd0, 3'd0, 32'h0},                  // R2
        '{4'd1,  OP_A, 1'b0, 2'd1, 16'h0, 64'h0, 32'h0000_0010, 2'd0, 3'd0, 32'h0001_2350},     // R1
        '{4'd1,  OP_A, 1'b0, 2'd1, 16'h0, 64'h0, 32'hFFFF_FFF0, 2'd1, 3'd0, 32'h0002_2330},     // R1
        '{4'd2,  OP_L, 1'b0, 2'd2, 16'hFFFF, 64'h0, 32'h0, 2'd0, 3'd0, 32'h0},                  // R2
        '{4'd1,  OP_A, 1'b0, 2'd2, 16'h0, 64'h0, 32'h0000_0020, 2'd0, 3'd0, 32'h0000_0010},     // R1 wrap
        '{4'd2,  OP_L, 1'b0, 2'd0, 16'h1000, 64'h0, 32'h0, 2'd0, 3'd0, 32'h0},                  // R2
        '{4'd9,  OP_A, 1'b1, 2'd0, 16'h0, 64'h0, 32'h0000_0004, 2'd2, 3'd0, 32'h0001_0004},     // R9
        '{4'd6,  OP_L, 1'b1, 2'd0, 16'h0008, mk(32'h0040_0000, 20'hFFFFF, 1, 0, 1, 1), 32'h0, 2'd0, 3'd0, 32'h0}, // R6
        '{4'd3,  OP_A, 1'b1, 2'd0, 16'h0, 64'h0, 32'h0000_0100, 2'd2, 3'd0, 32'h0040_0100},     // R3
        '{4'd4,  OP_A, 1'b1, 2'd0, 16'h0, 64'h0, 32'h0000_0050, 2'd1, 3'd3, 32'h0},             // R4
        '{4'd12, OP_L, 1'b1, 2'd1, 16'h0010, mk(32'h8000_0000, 20'h00FFF, 1, 0, 0, 1), 32'h0, 2'd0, 3'd0, 32'h0}, // R12
        '{4'd3,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_0FFF, 2'd1, 3'd0, 32'h8000_0FFF},     // R3 edge
        '{4'd3,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_1000, 2'd0, 3'd1, 32'h0},             // R3
        '{4'd4,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_0010, 2'd2, 3'd3, 32'h0},             // R4
        '{4'd5,  OP_L, 1'b1, 2'd2, 16'h0013, mk(32'h0, 20'hFFFFF, 1, 0, 0, 1), 32'h0, 2'd0, 3'd2, 32'h0}, // R5
        '{4'd7,  OP_A, 1'b1, 2'd2, 16'h0, 64'h0, 32'h0000_0020, 2'd0, 3'd0, 32'h0010_0010},     // R7
        '{4'd5,  OP_L, 1'b1, 2'd2, 16'h0013, mk(32'h0000_2000, 20'h000FF, 1, 3, 0, 0), 32'h0, 2'd0, 3'd0, 32'h0}, // R5
        '{4'd4,  OP_A, 1'b1, 2'd2, 16'h0, 64'h0, 32'h0000_0010, 2'd1, 3'd3, 32'h0},             // R4
        '{4'd3,  OP_A, 1'b1, 2'd2, 16'h0, 64'h0, 32'h0000_00FF, 2'd0, 3'd0, 32'h0000_20FF},     // R3
        '{4'd7,  OP_L, 1'b1, 2'd3, 16'h0018, mk(32'h0009_0000, 20'hFFFFF, 0, 0, 0, 1), 32'h0, 2'd0, 3'd4, 32'h0}, // R7
        '{4'd7,  OP_A, 1'b1, 2'd3, 16'h0, 64'h0, 32'h0000_0044, 2'd0, 3'd0, 32'h0000_0044},     // R7
        '{4'd8,  OP_S, 1'b1, 2'd1, 16'h0028, 64'h0, 32'h0, 2'd0, 3'd0, 32'h0},                  // R8
        '{4'd8,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_0020, 2'd0, 3'd0, 32'h8000_0020},     // R8
        '{4'd7,  OP_L, 1'b1, 2'd0, 16'h0008, mk(32'h0, 20'hFFFFF, 0, 0, 0, 1), 32'h0, 2'd0, 3'd3, 32'h0}, // R7 type first
        '{4'd7,  OP_L, 1'b1, 2'd0, 16'h0008, mk(32'h0, 20'hFFFFF, 0, 3, 1, 1), 32'h0, 2'd0, 3'd2, 32'h0}, // R7 priv first
        '{4'd5,  OP_L, 1'b1, 2'd1, 16'h0030, mk(32'h0000_0300, 20'hFFFFF, 1, 0, 1, 0), 32'h0, 2'd0, 3'd0, 32'h0}, // R5
        '{4'd4,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_0005, 2'd0, 3'd3, 32'h0},             // R4
        '{4'd4,  OP_A, 1'b1, 2'd1, 16'h0, 64'h0, 32'h0000_0005, 2'd2, 3'd0, 32'h0000_0305}      // R4
    };

    logic clk = 1'b0, rst_n = 1'b0, prot_mode = 1'b0;
    logic ld_valid = 1'b0, sw_valid = 1'b0, ac_valid = 1'b0;
    logic [1:0] ld_seg = '0, sw_seg = '0, ac_seg = '0, ac_kind = '0;
    logic [15:0] ld_sel = '0, sw_sel = '0;
    logic [63:0] ld_desc = '0;
    logic [31:0] ac_ofs = '0;
    logic ld_ack, ac_ack;
    logic [2:0] ld_fault, ac_fault;
    logic [31:0] ac_lin;
    logic [1:0] cur_cpl;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    segu_top u_segu_top (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc),
        .sw_valid(sw_valid), .sw_seg(sw_seg), .sw_sel(sw_sel),
        .ac_valid(ac_valid), .ac_seg(ac_seg), .ac_ofs(ac_ofs), .ac_kind(ac_kind),
        .ld_ack(ld_ack), .ld_fault(ld_fault), .ac_ack(ac_ack), .ac_fault(ac_fault),
        .ac_lin(ac_lin), .cur_cpl(cur_cpl)
    );

    task automatic chk(input int r, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // Drive one request on a falling edge; its response is sampled one period later
    task automatic run(input vec_t v);
        @(negedge clk);
        prot_mode = v.mode;
        case (v.op)
            OP_L: begin ld_valid = 1'b1; ld_seg = v.seg; ld_sel = v.sel; ld_desc = v.desc; end
            OP_A: begin ac_valid = 1'b1; ac_seg = v.seg; ac_ofs = v.ofs; ac_kind = v.kind; end
            default: begin sw_valid = 1'b1; sw_seg = v.seg; sw_sel = v.sel; end
        endcase
        @(negedge clk);
        ld_valid = 1'b0; ac_valid = 1'b0; sw_valid = 1'b0;
        if (v.op == OP_L) begin
            chk(int'(v.req), "ld_ack (R10)", 64'(ld_ack), 64'd1);
            chk(int'(v.req), "ld_fault", 64'(ld_fault), 64'(v.ef));
        end else if (v.op == OP_A) begin
            chk(int'(v.req), "ac_ack (R10)", 64'(ac_ack), 64'd1);
            chk(int'(v.req), "ac_fault", 64'(ac_fault), 64'(v.ef));
            chk(int'(v.req), "ac_lin", 64'(ac_lin), 64'(v.el));
        end
    endtask

    function automatic vec_t acc(input int r, input logic m, input logic [1:0] s,
                                 input logic [31:0] o, input logic [1:0] k,
                                 input logic [2:0] f, input logic [31:0] l);
        acc = '{4'(r), OP_A, m, s, 16'h0, 64'h0, o, k, f, l};
    endfunction

    function automatic vec_t lod(input int r, input logic [1:0] s, input logic [15:0] sl,
                                 input logic [63:0] d, input logic [2:0] f);
        lod = '{4'(r), OP_L, 1'b1, s, sl, d, 32'h0, 2'd0, f, 32'h0};
    endfunction

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(11, "ld_ack in reset", 64'(ld_ack), 64'd0);
        chk(11, "ac_ack in reset", 64'(ac_ack), 64'd0);
        chk(11, "cpl in reset", 64'(cur_cpl), 64'd0);
        rst_n = 1'b1;
        run(acc(11, 1'b1, 2'd3, 32'h0000_FFFF, 2'd2, 3'd0, 32'h0000_FFFF));
        run(acc(11, 1'b1, 2'd3, 32'h0001_0000, 2'd0, 3'd1, 32'h0));

        for (int i = 0; i < NV; i++) run(TBL[i]);

        // R8: selector-only write to register 0 changes CPL
        run('{4'd8, OP_S, 1'b1, 2'd0, 16'h0003, 64'h0, 32'h0, 2'd0, 3'd0, 32'h0});
        chk(8, "cpl after selector write", 64'(cur_cpl), 64'd3);
        run(acc(8, 1'b1, 2'd0, 32'h0000_0100, 2'd2, 3'd0, 32'h0040_0100));
        // R5: CPL 3 against privilege 2 data descriptor
        run(lod(5, 2'd1, 16'h0010, mk(32'h0, 20'hFFFFF, 1, 2, 0, 1), 3'd2));
        // R6: code load at matching level keeps CPL
        run(lod(6, 2'd0, 16'h0018, mk(32'h0000_5000, 20'h00FFF, 1, 3, 1, 1), 3'd0));
        chk(6, "cpl after code load", 64'(cur_cpl), 64'd3);
        run(acc(6, 1'b1, 2'd0, 32'h0000_0010, 2'd2, 3'd0, 32'h0000_5010));
        // R9: back to legacy, register 1 keeps protected base 0x300
        run(acc(9, 1'b0, 2'd1, 32'h0000_0010, 2'd1, 3'd0, 32'h0000_0310));
        // R10: acknowledges drop after an idle cycle
        @(negedge clk);
        chk(10, "ld_ack idle", 64'(ld_ack), 64'd0);
        chk(10, "ac_ack idle", 64'(ac_ack), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule